// File: doc/BRIEF.md
# Flash Write Strobe Qualifier

This block turns the asynchronous, active-low control pins of a NOR flash model into clean, synchronous command strobes. Chip enable, write enable, output enable, the pin reset and a digital low-supply flag are brought into a fast internal clock domain through synchronizer chains. The three bus-cycle controls then pass through minimum-width filters, so that a low pulse shorter than `MIN_W` sampling cycles can never open a write cycle.

A write cycle is armed only when chip enable and write enable are both held low and output enable is high. The rising edge of write enable completes the cycle, and the block then emits a one-cycle `cmdValid` pulse with the address and data bus values captured at that moment. Output enable low, chip enable high, a low supply and a low pin reset all inhibit writes. If write enable, chip enable and the pin reset are all low with output enable high when the block comes out of power-up, the first write-enable rising edge after that is swallowed. A level `readModeReq` tells the downstream command decoder to return to read-array mode. It is held during power-up, during pin reset and during supply lockout.

Top module: `flash_wr_qualifier`

## Requirements
- R1: With chip enable low, output enable high and write enable low for at least `MIN_W`+2 sampling cycles, the rising edge of write enable yields exactly one `cmdValid` pulse within 4 cycles. `cmdAddr`/`cmdData` carry the bus values, which are held stable for at least 4 cycles after that edge.
- R2: `cmdValid` is never high in two consecutive cycles, and `cmdAddr`/`cmdData` change only in the cycle in which `cmdValid` rises.
- R3: A write-enable low pulse shorter than `MIN_W` cycles produces no strobe.
- R4: A chip-enable low pulse shorter than `MIN_W` cycles, even while write enable is held low, produces no strobe.
- R5: Output enable held low through a write-enable pulse produces no strobe.
- R6: A write-enable pulse while chip enable is high produces no strobe.
- R7: While `lowSupply` is 1, every write is ignored and `readModeReq` is 1. Once it returns to 0, writes are accepted again and `readModeReq` drops to 0.
- R8: While `pinRstN` is 0, no strobe is produced and `readModeReq` is 1. Writes are accepted again once it is released.
- R9: If write enable, chip enable and pin reset are low with output enable high when `sysRstN` is released, the next write-enable rising edge produces no strobe. The write after that is accepted.
- R10: During `sysRstN` low, `readModeReq` is 1 and `cmdValid` is 0. After power-up, with pin reset high and `lowSupply` 0, `readModeReq` settles to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| sysRstN | input | 1 | Power-up reset of the sampling domain, active low |
| pinCeN | input | 1 | Chip enable pin, active low, asynchronous |
| pinWeN | input | 1 | Write enable pin, active low, asynchronous |
| pinOeN | input | 1 | Output enable pin, active low, asynchronous |
| pinRstN | input | 1 | Device reset pin, active low, asynchronous |
| lowSupply | input | 1 | Supply below lockout level flag, active high |
| addrIn | input | ADDR_W | Address bus |
| dataIn | input | DATA_W | Data bus |
| cmdValid | output | 1 | One-cycle qualified write strobe |
| cmdAddr | output | ADDR_W | Address captured with the strobe |
| cmdData | output | DATA_W | Data captured with the strobe |
| readModeReq | output | 1 | Request for the command logic to return to read-array mode |

## Verification
The hardest situation to reach is the power-up inhibit. It exists only in the few cycles in which the sampling domain leaves reset, and only with a particular mix of pin levels at that moment. The stimulus holds `sysRstN` low while write enable, chip enable and pin reset are driven low with output enable high. It then releases the system reset, then the pin reset, and only then raises write enable. A complete, otherwise valid write follows to show that the inhibit covered one edge only. The glitch cases place pulses of 2 cycles against a minimum of 4, on write enable and on chip enable separately.

// File: rtl/wq_pkg.sv
package wq_pkg;
  // Strobes from the control FSM into the capture datapath.
  typedef struct packed {
    logic capture;   // take the bus and pulse cmdValid
    logic readReq;   // ask the decoder to fall back to read-array mode
  } ctrlStrobe_t;
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wq_pin_filter.sv
module wq_pin_filter #(
  parameter int STAGES = 2,
  parameter int MIN_W  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic pinN,
  output logic levelHigh,
  output logic filtLow
);
  localparam int CNT_W = $clog2(MIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_W);

  logic [CNT_W-1:0] lowCnt;

  wq_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rstN(rstN), .d(pinN), .q(levelHigh)
  );

  // Counts consecutive low samples, saturating at MIN_W.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  lowCnt <= '0;
    else if (clear || levelHigh) lowCnt <= '0;
    else if (lowCnt != CNT_MAX) lowCnt <= lowCnt + 1'b1;
  end

  assign filtLow = (lowCnt == CNT_MAX);
endmodule

// File: rtl/wq_ctrl.sv
module wq_ctrl #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ceHigh,
  input  logic weHigh,
  input  logic oeHigh,
  input  logic ceFiltLow,
  input  logic weFiltLow,
  input  logic oeFiltLow,
  input  logic rstPinHigh,
  input  logic lockHigh,
  output logic filterClear,
  output wq_pkg::ctrlStrobe_t ctl
);
  localparam int START_END = STAGES + 1;
  localparam int START_W = $clog2(START_END + 1);
  localparam logic [START_W-1:0] EVAL_AT = START_W'(STAGES);
  localparam logic [START_W-1:0] DONE_AT = START_W'(START_END);

  logic [START_W-1:0] startCnt;
  logic startDone;
  logic armed;
  logic puBlock;
  logic blocked;
  logic fire;

  assign startDone = (startCnt == DONE_AT);
  assign blocked = !startDone || !rstPinHigh || lockHigh;
  assign fire = armed && weHigh && !blocked;
  assign filterClear = !rstPinHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt <= '0;
      armed <= 1'b0;
      puBlock <= 1'b0;
    end else begin
      if (!startDone) startCnt <= startCnt + 1'b1;

      // Power-up inhibit: judged once the synchronizers hold real pin values.
      if (startCnt == EVAL_AT)
        puBlock <= !weHigh && !ceHigh && !rstPinHigh && oeHigh;
      else if (puBlock && weHigh)
        puBlock <= 1'b0;

      if (blocked)
        armed <= 1'b0;
      else if (armed) begin
        if (weHigh || ceHigh || oeFiltLow) armed <= 1'b0;
      end else if (ceFiltLow && weFiltLow && oeHigh && !puBlock)
        armed <= 1'b1;
    end
  end

  always_comb begin
    ctl.capture = fire;
    ctl.readReq = blocked;
  end
endmodule

// File: rtl/wq_datapath.sv
module wq_datapath #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  wq_pkg::ctrlStrobe_t ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic readModeReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      readModeReq <= 1'b1;
      cmdAddr <= '0;
      cmdData <= '0;
    end else begin
      cmdValid <= ctl.capture;
      readModeReq <= ctl.readReq;
      if (ctl.capture) begin
        cmdAddr <= addrIn;
        cmdData <= dataIn;
      end
    end
  end
endmodule

// File: rtl/flash_wr_qualifier.sv
module flash_wr_qualifier #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int STAGES = 2,
  parameter int MIN_W  = 4
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic pinCeN,
  input  logic pinWeN,
  input  logic pinOeN,
  input  logic pinRstN,
  input  logic lowSupply,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic readModeReq
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pinVec;
  logic [NPINS-1:0] levelHigh;
  logic [NPINS-1:0] filtLow;
  logic rstPinHigh;
  logic lockHigh;
  logic filterClear;
  wq_pkg::ctrlStrobe_t ctl;

  assign pinVec = {pinOeN, pinWeN, pinCeN};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    wq_pin_filter #(.STAGES(STAGES), .MIN_W(MIN_W)) i_filt (
      .clk(clk), .rstN(sysRstN), .clear(filterClear),
      .pinN(pinVec[g]), .levelHigh(levelHigh[g]), .filtLow(filtLow[g])
    );
  end

  wq_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) i_rstSync (
    .clk(clk), .rstN(sysRstN), .d(pinRstN), .q(rstPinHigh)
  );

  wq_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) i_lockSync (
    .clk(clk), .rstN(sysRstN), .d(lowSupply), .q(lockHigh)
  );

  wq_ctrl #(.STAGES(STAGES)) i_ctrl (
    .clk(clk), .rstN(sysRstN),
    .ceHigh(levelHigh[0]), .weHigh(levelHigh[1]), .oeHigh(levelHigh[2]),
    .ceFiltLow(filtLow[0]), .weFiltLow(filtLow[1]), .oeFiltLow(filtLow[2]),
    .rstPinHigh(rstPinHigh), .lockHigh(lockHigh),
    .filterClear(filterClear), .ctl(ctl)
  );

  wq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(sysRstN), .ctl(ctl),
    .addrIn(addrIn), .dataIn(dataIn),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .readModeReq(readModeReq)
  );
endmodule

// File: rtl/wq_checker.sv
module wq_checker #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic clk,
  input logic sysRstN,
  input logic pinRstN,
  input logic lowSupply,
  input logic cmdValid,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [DATA_W-1:0] cmdData,
  input logic readModeReq
);
  // R2: strobe is one cycle wide
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!sysRstN)
    cmdValid |=> !cmdValid);

  // R2: outputs hold between strobes
  a_r2_hold_outputs: assert property (@(posedge clk) disable iff (!sysRstN)
    !cmdValid |-> ($stable(cmdAddr) && $stable(cmdData)));

  // R7: sustained low supply blocks strobes and requests read mode
  a_r7_lockout: assert property (@(posedge clk) disable iff (!sysRstN)
    (lowSupply && $past(lowSupply) && $past(lowSupply, 2) && $past(lowSupply, 3))
      |-> (!cmdValid && readModeReq));

  // R8: sustained pin reset blocks strobes and requests read mode
  a_r8_pin_reset: assert property (@(posedge clk) disable iff (!sysRstN)
    (!pinRstN && !$past(pinRstN) && !$past(pinRstN, 2) && !$past(pinRstN, 3))
      |-> (!cmdValid && readModeReq));
endmodule

bind flash_wr_qualifier wq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wqChk (
  .clk(clk), .sysRstN(sysRstN), .pinRstN(pinRstN), .lowSupply(lowSupply),
  .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
  .readModeReq(readModeReq)
);

// File: tb/test_flash_wr_qualifier.sv
module test_flash_wr_qualifier;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int MIN_W = 4;

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic pinCeN = 1'b0, pinWeN = 1'b0, pinOeN = 1'b1, pinRstN = 1'b0;
  logic lowSupply = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic cmdValid;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;
  logic readModeReq;

  int checks = 0;
  int failures = 0;
  string curReq = "R10";
  logic [ADDR_W+DATA_W-1:0] expQ[$];

  always #5 clk = ~clk;

  flash_wr_qualifier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_W(MIN_W)) i_flash_wr_qualifier (
    .clk(clk), .sysRstN(sysRstN), .pinCeN(pinCeN), .pinWeN(pinWeN),
    .pinOeN(pinOeN), .pinRstN(pinRstN), .lowSupply(lowSupply),
    .addrIn(addrIn), .dataIn(dataIn), .cmdValid(cmdValid),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .readModeReq(readModeReq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every strobe must match the head of the scoreboard queue.
  always @(negedge clk) begin
    if (sysRstN && cmdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, curReq, "unexpected strobe", {cmdAddr, cmdData}, 0);
      end else begin
        logic [ADDR_W+DATA_W-1:0] exp;
        exp = expQ.pop_front();
        check({cmdAddr, cmdData} == exp, curReq, "strobe addr/data",
              {cmdAddr, cmdData}, exp);
      end
    end
  end

  // Driver: a write cycle, with the bus held well past the WE rising edge.
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input int weLow, input bit accept, input string req);
    curReq = req;
    addrIn = a; dataIn = d;
    pinCeN = 1'b0;
    tick(2);
    pinWeN = 1'b0;
    tick(weLow);
    if (accept) expQ.push_back({a, d});
    pinWeN = 1'b1;
    tick(6);
    pinCeN = 1'b1;
    tick(4);
    check(expQ.size() == 0, req, "pending expected strobes", expQ.size(), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    // R10 reset state, with the R9 power-up pattern on the pins
    tick(3);
    check(readModeReq == 1'b1, "R10", "readModeReq in reset", readModeReq, 1);
    check(cmdValid == 1'b0, "R10", "cmdValid in reset", cmdValid, 0);
    sysRstN = 1'b1;
    tick(10);
    check(readModeReq == 1'b1, "R8", "readModeReq with pin reset low", readModeReq, 1);
    curReq = "R9";
    pinRstN = 1'b1;
    tick(12);
    pinWeN = 1'b1;
    tick(8);
    pinCeN = 1'b1;
    tick(4);
    check(expQ.size() == 0, "R9", "no strobe after power-up edge", expQ.size(), 0);
    check(readModeReq == 1'b0, "R10", "readModeReq idle", readModeReq, 0);
    doWrite(22'h000555, 16'h00AA, 10, 1'b1, "R9");

    // R1 several distinct patterns
    doWrite(22'h0002AA, 16'h0055, 10, 1'b1, "R1");
    doWrite(22'h3FFFFF, 16'hFFFF, MIN_W + 2, 1'b1, "R1");
    doWrite(22'h000000, 16'h0000, 20, 1'b1, "R1");
    doWrite(22'h155555, 16'hA5C3, 7, 1'b1, "R2");

    // R3 short WE pulse
    doWrite(22'h000123, 16'h1234, 2, 1'b0, "R3");
    doWrite(22'h000124, 16'h1235, 9, 1'b1, "R3");

    // R4 short CE pulse while WE low
    curReq = "R4";
    addrIn = 22'h000777; dataIn = 16'h7777;
    pinWeN = 1'b0; tick(2);
    pinCeN = 1'b0; tick(2);
    pinCeN = 1'b1; tick(10);
    pinWeN = 1'b1; tick(8);
    check(expQ.size() == 0, "R4", "no strobe on short CE", expQ.size(), 0);

    // R5 OE held low
    pinOeN = 1'b0;
    doWrite(22'h000888, 16'h8888, 10, 1'b0, "R5");
    pinOeN = 1'b1;
    tick(4);

    // R6 CE high during WE pulse
    curReq = "R6";
    pinWeN = 1'b0; tick(10);
    pinWeN = 1'b1; tick(8);
    check(expQ.size() == 0, "R6", "no strobe with CE high", expQ.size(), 0);

    // R7 lockout
    lowSupply = 1'b1;
    tick(6);
    check(readModeReq == 1'b1, "R7", "readModeReq under lockout", readModeReq, 1);
    doWrite(22'h000999, 16'h9999, 10, 1'b0, "R7");
    lowSupply = 1'b0;
    tick(6);
    check(readModeReq == 1'b0, "R7", "readModeReq after lockout", readModeReq, 0);
    doWrite(22'h00099A, 16'h999A, 10, 1'b1, "R7");

    // R8 pin reset
    pinRstN = 1'b0;
    tick(6);
    check(readModeReq == 1'b1, "R8", "readModeReq under pin reset", readModeReq, 1);
    doWrite(22'h000AAA, 16'hAAAA, 10, 1'b0, "R8");
    pinRstN = 1'b1;
    tick(6);
    check(readModeReq == 1'b0, "R8", "readModeReq after pin reset", readModeReq, 0);
    doWrite(22'h000AAB, 16'hAAAB, 10, 1'b1, "R8");

    tick(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule